// File: doc/BRIEF.md
# Sleep Timer with Two-Step Compare Loading

This block is a sleep timer. An up-counter advances on an external tick while the timer is enabled, and a sticky interrupt flag is raised when the count reaches a compare value. The compare value is twice as wide as the data path that software uses to load it. Software therefore loads it in two writes, low half first and high half second.

A low-half write only parks its data in a staging register. The following high-half write moves both halves into the live comparator on the same clock edge, so the comparator never works against a value that is half old and half new. Both compare writes are dropped while the timer is enabled, because changing the target under a running count can raise a false interrupt.

Software first clears the enable bit, writes the low half and then the high half, and sets the enable bit again. It services the interrupt by writing 1 to the flag bit. All register reads go through a registered read port.

Top module: `sleep_cmp_timer`

## Requirements
- R1: After reset the staged low half (address 1) reads all ones in its low HALF_W bits, the active low half (address 5) reads all ones, the high half (address 2), the count (address 4), the configuration (address 0) and the flag (address 3) read zero, and `irq` is low.
- R2: A write to address 1 while disabled stores data bits [HALF_W-1:0] in the staging register, and a read of address 1 returns that value with every higher bit zero. The active compare value (address 5 and address 2) does not change.
- R3: A write to address 2 while disabled loads data bits [HALF_W-1:0] as the high half and the staged value as the low half of the active compare value, both on the same edge.
- R4: While the enable bit is 1, writes to address 1 and address 2 leave both the staging register and the active compare value unchanged.
- R5: The counter rises by one on each clock edge where `tick` is high and the enable bit is 1. It does not move while disabled, and it wraps from all ones to zero.
- R6: The flag (read at address 3, bit 0, and driven on `irq`) is set on the edge where the counter steps to a value equal to the active compare value, including the step that wraps to zero.
- R7: The flag stays set until a write to address 3 with data bit 0 at 1. A write to address 3 with bit 0 at 0 leaves the flag unchanged.
- R8: The enable bit is bit 11 of address 0. The other bits of address 0 are not stored and read as zero.
- R9: When a clearing write to address 3 and a new match fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read address; data appears after the next edge |
| rd_data | output | DATA_W | Registered read data |
| tick | input | 1 | Count tick, sampled each clock |
| irq | output | 1 | Sticky compare-match interrupt flag |

## Verification
The assertions assume that `tick` and the write strobe are sampled as clean synchronous levels, and that the reset is held for at least one edge before any check applies. The stimulus changes every input on the falling clock edge, holds `tick` as a level for an exact number of edges, and writes only mapped addresses. The bench reconfigures the compare value only after it has written the enable bit to 0. It writes compare halves while enabled only on purpose, to test that those writes are dropped.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int ADDR_W = 3;
  localparam int EN_BIT = 11;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LO    = 3'd1;
  localparam logic [ADDR_W-1:0] A_HI    = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACTLO = 3'd5;
endpackage

// File: rtl/stm_regs.sv
module stm_regs
  import stm_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic [DATA_W-1:0] rd_data,
  output logic              enable,
  output logic [CNT_W-1:0]  cmp,
  output logic              clr
);
  logic [HALF_W-1:0] hold_q;
  logic              wr_lo, wr_hi, wr_cfg;

  assign wr_cfg = wr_en && (wr_addr == A_CFG);
  assign wr_lo  = wr_en && (wr_addr == A_LO) && !enable;
  assign wr_hi  = wr_en && (wr_addr == A_HI) && !enable;
  assign clr    = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      hold_q <= '1;
      cmp    <= {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    end else begin
      if (wr_cfg) enable <= wr_data[EN_BIT];
      if (wr_lo)  hold_q <= wr_data[HALF_W-1:0];
      if (wr_hi)  cmp    <= {wr_data[HALF_W-1:0], hold_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CFG:   rd_data <= DATA_W'(enable) << EN_BIT;
        A_LO:    rd_data <= DATA_W'(hold_q);
        A_HI:    rd_data <= DATA_W'(cmp[CNT_W-1:HALF_W]);
        A_STAT:  rd_data <= DATA_W'(flag);
        A_COUNT: rd_data <= DATA_W'(cnt);
        A_ACTLO: rd_data <= DATA_W'(cmp[HALF_W-1:0]);
        default: rd_data <= '0;
      endcase
    end
  end

  // R4: compare writes are dropped while the timer runs
  assert_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && wr_en && (wr_addr == A_LO || wr_addr == A_HI))
      |=> ($stable(cmp) && $stable(hold_q)));

  // R3: both halves land together
  assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
    (!enable && wr_en && wr_addr == A_HI)
      |=> (cmp == {$past(wr_data[HALF_W-1:0]), $past(hold_q)}));

  // R2: a low write leaves the live value alone
  assert_stage_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_LO) |=> $stable(cmp));
endmodule

// File: rtl/stm_counter.sv
module stm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (enable && tick) cnt <= cnt_nxt;
  end

  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !(enable && tick) |=> $stable(cnt));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && tick) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/stm_match.sv
module stm_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             clr,
  output logic             flag
);
  logic hit;
  assign hit = enable && tick && (cnt_nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_set_R6: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  // R9: a match on the clearing edge keeps the flag
  assert_setwins_R9: assert property (@(posedge clk) disable iff (rst)
    (hit && clr) |=> flag);
endmodule

// File: rtl/sleep_cmp_timer.sv
module sleep_cmp_timer
  import stm_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  output logic              irq
);
  localparam int CNT_W = 2 * HALF_W;

  logic             enable, clr, flag;
  logic [CNT_W-1:0] cmp, cnt, cnt_nxt;

  stm_regs #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .flag(flag),
    .rd_data(rd_data), .enable(enable), .cmp(cmp), .clr(clr)
  );

  stm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick),
    .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  stm_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick),
    .cnt_nxt(cnt_nxt), .cmp(cmp), .clr(clr), .flag(flag)
  );

  assign irq = flag;
endmodule

// File: tb/tb_sleep_cmp_timer.sv
module tb_sleep_cmp_timer;
  localparam int HALF_W = 8;
  localparam int DATA_W = 32;
  localparam int EN     = 32'h800;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [2:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              tick = 1'b0;
  logic              irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic fire = 1'b0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #2 clk = ~clk;

  sleep_cmp_timer #(.HALF_W(HALF_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick(tick), .irq(irq)
  );

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk); rd_addr = a; exp_q.push_back(e); tag_q.push_back(t); fire = 1'b1;
    @(negedge clk); fire = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  // monitor: pops the expected read value after the capturing edge
  always @(posedge clk) begin
    if (fire) begin
      #1;
      n_cmp++;
      if (rd_data !== exp_q[0]) begin
        n_bad++;
        $display("FAIL %s rd actual=%h expected=%h", tag_q[0], rd_data, exp_q[0]);
      end
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
      end
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(3'd1, 32'h0000_00FF, "R1");
        rd(3'd5, 32'h0000_00FF, "R1");
        rd(3'd2, 0, "R1");
        rd(3'd4, 0, "R1");
        rd(3'd0, 0, "R1");
        rd(3'd3, 0, "R1");
        chk_irq(1'b0, "R1");
        // R2 staging
        wr(3'd1, 32'hFFFF_FF10);
        rd(3'd1, 32'h0000_0010, "R2");
        rd(3'd5, 32'h0000_00FF, "R2");
        // R3 commit -> compare 0x0010
        wr(3'd2, 32'h0000_0000);
        rd(3'd5, 32'h0000_0010, "R3");
        rd(3'd2, 0, "R3");
        // R8 other config bits do nothing
        wr(3'd0, 32'hFFFF_F7FF);
        rd(3'd0, 0, "R8");
        ticks(5);
        rd(3'd4, 0, "R5");
        wr(3'd0, EN);
        rd(3'd0, EN, "R8");
        ticks(5);
        rd(3'd4, 5, "R5");
        chk_irq(1'b0, "R6");
        // R4 writes dropped while running
        wr(3'd1, 32'h99);
        wr(3'd2, 32'h77);
        rd(3'd1, 32'h10, "R4");
        rd(3'd2, 0, "R4");
        rd(3'd5, 32'h10, "R4");
        // R6 match
        ticks(10);
        chk_irq(1'b0, "R6");
        ticks(1);
        chk_irq(1'b1, "R6");
        rd(3'd4, 16, "R6");
        // R7 sticky and W1C
        ticks(3);
        chk_irq(1'b1, "R7");
        wr(3'd3, 0);
        chk_irq(1'b1, "R7");
        wr(3'd3, 1);
        chk_irq(1'b0, "R7");
        rd(3'd3, 0, "R7");
        // R5 disabled holds count at 19
        wr(3'd0, 0);
        ticks(3);
        rd(3'd4, 19, "R5");
        // R9 set beats clear: compare 20
        wr(3'd1, 32'h14);
        wr(3'd2, 0);
        wr(3'd0, EN);
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd3; wr_data = 1; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        chk_irq(1'b1, "R9");
        rd(3'd4, 20, "R9");
        // R5/R6 wrap to zero matches compare 0
        wr(3'd0, 0);
        wr(3'd1, 0);
        wr(3'd2, 0);
        wr(3'd3, 1);
        wr(3'd0, EN);
        ticks(65515);
        rd(3'd4, 32'hFFFF, "R5");
        chk_irq(1'b0, "R6");
        ticks(1);
        rd(3'd4, 0, "R5");
        chk_irq(1'b1, "R6");
        repeat (2) @(negedge clk);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule